// File: doc/BRIEF.md
# UART Receive FIFO with Line Status

This block sits between a UART's bit-level deserializer and the host. Each received character arrives on a one-cycle strobe, carrying three error tags: parity error, framing error and break. The block stores the character and its tags in an 8-entry FIFO. When the FIFO is turned off, the store acts as a single holding register. A byte-wide register interface lets the host pop characters, read a receive count, and set up the FIFO. Through the same interface the host reads a status byte. That byte combines live flags with sticky error bits that clear when the byte is read.

A trigger output tells the host when enough characters are waiting, at a selectable level of 1, 2, 4 or 7 bytes. A character that arrives while the store is full is dropped, and the overrun flag is raised. The two transmit-empty inputs are only mirrored into the status byte.

Top module: `uart_rx_fifo_status`

Register offsets on `reg_addr`:

| Offset | Register | Access |
|---|---|---|
| 0 | Receive buffer | read pops the head character |
| 1 | Control | read and write |
| 2 | Status | read |
| 3 | Receive count | read |

Control byte fields: bit0 enables the FIFO, bit1 is the receive clear, and bits 7:6 select the trigger level.

## Requirements
- R1: After reset the count reads 0 and the control byte reads 0x00 (FIFO off, trigger field 0). The status byte has bits 0 to 4 and bit 7 clear, and `rx_trigger` is low.
- R2: A read returns its data on `reg_rdata` in the cycle after the strobe. A read of offset 0 returns the head character and removes it, so characters come out in arrival order.
- R3: With control bit0 set, the store holds up to 8 characters. Offset 3 reports how many it holds. Control bits 7:6 and bit0 read back as written.
- R4: With control bit0 clear, the store holds at most 1 character.
- R5: A character that arrives while the store is full is discarded, the stored characters and the count are unchanged, and status bit1 (overrun) is set.
- R6: Status byte layout:

  | Bit | Meaning |
  |---|---|
  | 0 | data ready (count not 0) |
  | 1 | overrun |
  | 2 | parity error |
  | 3 | framing error |
  | 4 | break |
  | 5 | mirrors `tx_fifo_empty` |
  | 6 | mirrors `tx_all_empty` |
  | 7 | error entry in FIFO |

- R7: Status bits 1 to 4 are sticky. A status read clears them, unless the condition that sets them is still present.
- R8: Status bits 2, 3 and 4 are set when the head character carries the parity, framing or break tag. An errored character behind the head does not set them.
- R9: Status bit7 is high exactly while at least one stored character carries any error tag.
- R10: `rx_trigger` is high while the count is at least the selected threshold. The threshold is 1 for trigger field 0, 2 for 1, 4 for 2 and 7 for 3.
- R11: Writing control with bit1 set empties the store. Bit1 always reads back as 0.
- R12: A read of offset 0 while the store is empty returns 0x00 and leaves the count and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error tag |
| rx_ferr | input | 1 | Framing error tag |
| rx_brk | input | 1 | Break tag |
| tx_fifo_empty | input | 1 | Transmit FIFO empty, mirrored to status bit5 |
| tx_all_empty | input | 1 | Transmit holding and shift register empty, mirrored to status bit6 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rx_trigger | output | 1 | Count has reached the trigger threshold |

## Verification
The hardest case to reach is the difference between an errored character at the head and one waiting behind it. The bench stacks a clean character in front of a framing-error character and checks that only the summary bit rises. It then pops the clean one and checks that the framing bit appears. Sticky clearing is tested by popping the errored character and reading status twice: the first read still shows the error bit, and the second shows it cleared. Overrun is reached in both depth modes by pushing past capacity. Afterwards the scoreboard drains the store and confirms that the dropped character never appears.

// File: rtl/uart_rxf_pkg.sv
`timescale 1ns/1ps
package uart_rxf_pkg;
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rxf_entry_t;

  function automatic int unsigned rxf_thresh(input logic [1:0] sel);
    case (sel)
      2'd0:    rxf_thresh = 1;
      2'd1:    rxf_thresh = 2;
      2'd2:    rxf_thresh = 4;
      default: rxf_thresh = 7;
    endcase
  endfunction
endpackage

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store
  import uart_rxf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             fifo_en,
  input  logic             push,
  input  rxf_entry_t       push_ent,
  input  logic             pop,
  output rxf_entry_t       head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             err_any
);
  rxf_entry_t       mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CNT_W-1:0] err_cnt;
  logic             accept, take;
  logic             push_bad, head_bad;

  // single-entry holding register when the FIFO is off
  assign full     = fifo_en ? (count == CNT_W'(DEPTH)) : (count != '0);
  assign accept   = push && !full && !clr;
  assign take     = pop && (count != '0) && !clr;
  assign head     = mem[rptr];
  assign push_bad = push_ent.perr | push_ent.ferr | push_ent.brk;
  assign head_bad = head.perr | head.ferr | head.brk;
  assign err_any  = (err_cnt != '0);

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      if (accept) wptr <= wptr + AW'(1);
      if (take)   rptr <= rptr + AW'(1);
      count   <= count + CNT_W'(accept) - CNT_W'(take);
      err_cnt <= err_cnt + CNT_W'(accept && push_bad) - CNT_W'(take && head_bad);
    end
  end
endmodule

// File: rtl/rxf_flags.sv
`timescale 1ns/1ps
module rxf_flags (
  input  logic clk,
  input  logic rst,
  input  logic rd_clear,
  input  logic set_ovr,
  input  logic head_vld,
  input  logic head_perr,
  input  logic head_ferr,
  input  logic head_brk,
  output logic ovr,
  output logic perr,
  output logic ferr,
  output logic brk
);
  // a set condition wins over a clearing read in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr  <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
      brk  <= 1'b0;
    end else begin
      ovr  <= set_ovr                | (ovr  & ~rd_clear);
      perr <= (head_vld & head_perr) | (perr & ~rd_clear);
      ferr <= (head_vld & head_ferr) | (ferr & ~rd_clear);
      brk  <= (head_vld & head_brk)  | (brk  & ~rd_clear);
    end
  end
endmodule

// File: rtl/uart_rx_fifo_status.sv
`timescale 1ns/1ps
module uart_rx_fifo_status
  import uart_rxf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic              tx_fifo_empty,
  input  logic              tx_all_empty,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              rx_trigger
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] OFS_BUF  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(3);

  logic             en_q;
  logic [1:0]       trig_q;
  logic             rd_buf, rd_stat, wr_ctrl, rx_clr;
  rxf_entry_t       in_ent, head_ent;
  logic [CNT_W-1:0] rx_cnt, thr;
  logic             rx_full, err_any;
  logic             flag_oe, flag_pe, flag_fe, flag_bi;
  logic [7:0]       stat_byte;

  assign rd_buf  = reg_rd && (reg_addr == OFS_BUF);
  assign rd_stat = reg_rd && (reg_addr == OFS_STAT);
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign rx_clr  = wr_ctrl && reg_wdata[1];

  always_comb begin
    in_ent.data = rx_data;
    in_ent.perr = rx_perr;
    in_ent.ferr = rx_ferr;
    in_ent.brk  = rx_brk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      trig_q <= 2'd0;
    end else if (wr_ctrl) begin
      en_q   <= reg_wdata[0];
      trig_q <= reg_wdata[7:6];
    end
  end

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .clr      (rx_clr),
    .fifo_en  (en_q),
    .push     (rx_valid),
    .push_ent (in_ent),
    .pop      (rd_buf),
    .head     (head_ent),
    .count    (rx_cnt),
    .full     (rx_full),
    .err_any  (err_any)
  );

  rxf_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .rd_clear  (rd_stat),
    .set_ovr   (rx_valid && rx_full && !rx_clr),
    .head_vld  (rx_cnt != '0),
    .head_perr (head_ent.perr),
    .head_ferr (head_ent.ferr),
    .head_brk  (head_ent.brk),
    .ovr       (flag_oe),
    .perr      (flag_pe),
    .ferr      (flag_fe),
    .brk       (flag_bi)
  );

  assign thr        = CNT_W'(rxf_thresh(trig_q));
  assign rx_trigger = (rx_cnt >= thr);
  assign stat_byte  = {err_any, tx_all_empty, tx_fifo_empty,
                       flag_bi, flag_fe, flag_pe, flag_oe, (rx_cnt != '0)};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= 8'h00;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_BUF:  reg_rdata <= (rx_cnt != '0) ? head_ent.data : 8'h00;
        OFS_CTRL: reg_rdata <= {trig_q, 5'b00000, en_q};
        OFS_STAT: reg_rdata <= stat_byte;
        OFS_CNT:  reg_rdata <= 8'(rx_cnt);
        default:  reg_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rxf_checker.sv
`timescale 1ns/1ps
module rxf_checker #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_full,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic              flag_oe,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              rx_trigger
);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CNT_W'(DEPTH));

  assert_overrun_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_full && !reg_rd && !reg_wr |=> flag_oe && $stable(rx_cnt));

  assert_empty_read_zero_R12: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == ADDR_W'(0) && rx_cnt == '0 && !rx_valid && !reg_wr
    |=> reg_rdata == 8'h00 && rx_cnt == '0);

  assert_pop_decrements_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == ADDR_W'(0) && rx_cnt != '0 && !rx_valid && !reg_wr
    |=> rx_cnt == $past(rx_cnt) - CNT_W'(1));

  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[1] |=> rx_cnt == '0);

  assert_trigger_needs_data_R10: assert property (@(posedge clk) disable iff (rst)
    rx_trigger |-> rx_cnt != '0);
endmodule

bind uart_rx_fifo_status rxf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_valid   (rx_valid),
  .rx_full    (rx_full),
  .rx_cnt     (rx_cnt),
  .flag_oe    (flag_oe),
  .reg_rd     (reg_rd),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .rx_trigger (rx_trigger)
);

// File: tb/uart_rx_fifo_status_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo_status_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic       tx_fifo_empty = 1'b1, tx_all_empty = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rx_trigger;

  always #2.5 clk = ~clk;

  uart_rx_fifo_status u_uart_rx_fifo_status (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .tx_fifo_empty(tx_fifo_empty), .tx_all_empty(tx_all_empty),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_trigger(rx_trigger)
  );

  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;
  logic [7:0] model_q[$];
  logic [7:0] exp_q[$];
  bit         model_en = 1'b0;
  logic       buf_rd_d = 1'b0;
  logic [7:0] v;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: character into the design and into the model
  task automatic push_ch(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    if (model_q.size() < (model_en ? 8 : 1)) model_q.push_back(d);
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] val);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    if (a == 2'd0) exp_q.push_back(model_q.size() != 0 ? model_q.pop_front() : 8'h00);
    @(negedge clk);
    val = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 2'd1) begin
      model_en = d[0];
      if (d[1]) model_q.delete();
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pop_ch();
    logic [7:0] dummy;
    rd(2'd0, dummy);
  endtask

  // monitor: compares each buffer read with the scoreboard head (R2)
  always @(posedge clk) buf_rd_d <= reg_rd && (reg_addr == 2'd0);
  always @(negedge clk) begin
    if (buf_rd_d) begin
      if (exp_q.size() != 0) check("R2 buffer order", reg_rdata, exp_q.pop_front());
      else check("R2 unexpected buffer read", 8'hxx, 8'h00);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd2, v); check("R1 status", v, 8'h60);
    rd(2'd1, v); check("R1 ctrl", v, 8'h00);
    rd(2'd3, v); check("R1 count", v, 8'h00);
    check("R1 trigger", {7'd0, rx_trigger}, 8'h00);

    // R4 depth one when off, R5 overrun
    push_ch(8'h11, 0, 0, 0);
    push_ch(8'h22, 0, 0, 0);
    rd(2'd3, v); check("R4 count", v, 8'h01);
    rd(2'd2, v); check("R5 overrun set", v, 8'h63);
    rd(2'd2, v); check("R7 overrun cleared", v, 8'h61);
    pop_ch();
    rd(2'd3, v); check("R4 count after pop", v, 8'h00);

    // R12 empty read
    pop_ch();
    rd(2'd3, v); check("R12 count", v, 8'h00);
    rd(2'd2, v); check("R12 status", v, 8'h60);

    // R3 / R10 FIFO on, trigger levels
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R3 ctrl readback", v, 8'h01);
    check("R10 trig0 empty", {7'd0, rx_trigger}, 8'h00);
    push_ch(8'h30, 0, 0, 0);
    check("R10 trig0 at 1", {7'd0, rx_trigger}, 8'h01);
    wr(2'd1, 8'h81);
    check("R10 trig2 at 1", {7'd0, rx_trigger}, 8'h00);
    push_ch(8'h31, 0, 0, 0);
    push_ch(8'h32, 0, 0, 0);
    check("R10 trig2 at 3", {7'd0, rx_trigger}, 8'h00);
    push_ch(8'h33, 0, 0, 0);
    check("R10 trig2 at 4", {7'd0, rx_trigger}, 8'h01);
    wr(2'd1, 8'hC1);
    check("R10 trig3 at 4", {7'd0, rx_trigger}, 8'h00);
    push_ch(8'h34, 0, 0, 0);
    push_ch(8'h35, 0, 0, 0);
    check("R10 trig3 at 6", {7'd0, rx_trigger}, 8'h00);
    push_ch(8'h36, 0, 0, 0);
    check("R10 trig3 at 7", {7'd0, rx_trigger}, 8'h01);
    wr(2'd1, 8'h41);
    check("R10 trig1 at 7", {7'd0, rx_trigger}, 8'h01);
    push_ch(8'h37, 0, 0, 0);
    rd(2'd3, v); check("R3 count full", v, 8'h08);
    push_ch(8'hEE, 0, 0, 0);
    rd(2'd3, v); check("R5 count kept", v, 8'h08);
    rd(2'd2, v); check("R5 overrun full", v, 8'h63);
    for (int i = 0; i < 8; i++) pop_ch();
    rd(2'd2, v); check("R5 drained status", v, 8'h60);

    // R11 clear
    push_ch(8'h41, 0, 0, 0);
    push_ch(8'h42, 0, 0, 0);
    push_ch(8'h43, 0, 0, 0);
    wr(2'd1, 8'hC3);
    rd(2'd3, v); check("R11 count", v, 8'h00);
    rd(2'd1, v); check("R11 bit1 reads 0", v, 8'hC1);
    rd(2'd2, v); check("R11 status", v, 8'h60);
    pop_ch();

    // R8 / R9 error tags
    wr(2'd1, 8'h01);
    push_ch(8'h55, 1, 0, 0);
    rd(2'd2, v); check("R8 parity head", v, 8'hE5);
    push_ch(8'h66, 0, 0, 0);
    pop_ch();
    rd(2'd2, v); check("R7 parity sticky", v, 8'h65);
    rd(2'd2, v); check("R7 parity cleared", v, 8'h61);
    push_ch(8'h77, 0, 1, 0);
    rd(2'd2, v); check("R8 framing behind head", v, 8'hE1);
    pop_ch();
    rd(2'd2, v); check("R8 framing at head", v, 8'hE9);
    pop_ch();
    rd(2'd2, v); check("R9 summary gone", v, 8'h68);
    rd(2'd2, v); check("R7 framing cleared", v, 8'h60);
    push_ch(8'h88, 0, 0, 1);
    rd(2'd2, v); check("R8 break head", v, 8'hF1);
    pop_ch();
    rd(2'd2, v); check("R7 break sticky", v, 8'h70);
    rd(2'd2, v); check("R7 break cleared", v, 8'h60);

    // R6 transmit mirrors
    tx_fifo_empty = 1'b0; tx_all_empty = 1'b0;
    rd(2'd2, v); check("R6 tx both low", v, 8'h00);
    tx_fifo_empty = 1'b1;
    rd(2'd2, v); check("R6 bit5", v, 8'h20);
    tx_fifo_empty = 1'b0; tx_all_empty = 1'b1;
    rd(2'd2, v); check("R6 bit6", v, 8'h40);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule